// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a serial peripheral master that a processor drives through a small word-wide register port. Software picks the clock polarity, the sampling phase, the bit order and an 8- or 9-bit word size. It sets an 8-bit divider that derives the serial clock from the block clock. It then writes words into a holding register. Each held word moves into the shifter when the wire is free. A second word can therefore wait while the first is being shifted, and the chip select stays low across the pair.

Each incoming word lands in a receive data register and raises a receive-complete flag. A word that arrives while the previous one is still unread raises an overflow bit, and that word reads back as zero. A mask register, with separate set and clear addresses, gates three flags onto a single interrupt line: holding-register-empty, receive-complete and overflow. Enabling or disabling the block takes effect only after a short synchronization delay, and the divider can be rewritten only while the block is fully disabled.

Top module: `spi_dbuf_master`

## Requirements
- R1: With divider value D (address 1), every serial clock half period lasts D+1 block clock cycles. The first clock edge comes one half period after chip select falls, so the serial clock runs at the block clock divided by 2×(D+1).
- R2: In the control register (address 0), bit 2 sets the clock idle level (polarity) and bit 3 sets the phase. With phase 0, the first bit is on the data output before the first edge, the leading edge samples and the trailing edge shifts. With phase 1, data changes on the leading edge and is sampled on the trailing edge. The clock rests at the polarity level while chip select is high.
- R3: Control bit 4 set sends and receives least significant bit first, and clear sends most significant first. Control bit 5 set selects 9-bit words, and clear selects 8-bit words. A 9-bit word occupies bits 8:0 of the data register (address 5).
- R4: Status bit 0 (address 4) reads 1 when the holding register is empty. A data write clears it, and it returns to 1 once the word moves into the shifter. While the block is disabled, a written word waits in the holding register.
- R5: Status bit 1 is set when a received word is in the data register and cleared by reading the data register. With control bit 1 (receiver enable) clear, the flag is cleared and stays clear, and received words are discarded, leaving the data register unchanged.
- R6: A word that completes while status bit 1 is set sets status bit 2 (overflow) and makes the data register read 0. Writing 1 to status bit 2 clears it.
- R7: The interrupt mask reads at addresses 2 and 3. Writing 1s at address 2 sets mask bits, and writing 1s at address 3 clears them. Mask bit 0 gates the empty flag, bit 1 receive-complete and bit 2 overflow. The interrupt output is the OR of the flags gated by the mask.
- R8: Changing control bit 0 (enable) sets status bit 3 (sync busy) for SYNC_CYCLES cycles. The new enable state, and with it the start of transfers, takes effect only when busy clears.
- R9: A divider write is ignored while the block is enabled or a sync is pending.
- R10: If the holding register is full when a word ends, the next word starts at once and chip select stays low. Otherwise chip select rises one half period after the last clock edge.
- R11: After reset, the control register reads 0x02 (receiver enabled, mode 0, MSB first, 8-bit, disabled), status reads 0x01, chip select is high, the clock is low and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (reference) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data read) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Some properties are checked by the in-line assertions on every cycle:
- the clock stays at its idle level while chip select is high;
- the divider never changes while the block is enabled;
- the enable state changes only at the end of a busy window;
- overflow rises only over an unread word;
- receive-complete stays clear while the receiver is off.

Other behaviour depends on stimulus, and only the directed scenarios can show it:
- correct bit exchange in all four modes, both orders and both sizes, using a bench-side slave;
- the measured half-period and chip-select release times;
- chip select held low across back-to-back words;
- the zero word after an overflow;
- the interrupt masking.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int BAUD_W      = 8,
  parameter int SYNC_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int MAXB = 9;
  localparam int SW   = $clog2(SYNC_CYCLES + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_BAUD = 3'd1, A_MSET = 3'd2,
                         A_MCLR = 3'd3, A_STAT = 3'd4, A_DATA = 3'd5;

  typedef enum logic [1:0] {IDLE, RUN, TAIL} st_t;

  logic              en_req, en_eff, rxen, cpol, cpha, lsb, nine;
  logic [BAUD_W-1:0] baud, div;
  logic [SW-1:0]     sync_cnt;
  logic [2:0]        mask;
  logic [MAXB-1:0]   hold, txw, rxw, rx_next, rxd;
  logic              hold_full, rxc, ovf, ph, mosi_q, cs_q;
  logic [4:0]        hi;
  st_t               st;

  logic [3:0] nb, bit_k;
  logic       tick, lead, last_half, samp, word_done, busy;
  logic       wr_data, rd_data, wr_ctrl;
  logic [MAXB-1:0] wmask;
  logic       unused_ok;

  function automatic logic [3:0] bpos(input logic [3:0] k, input logic l, input logic [3:0] n);
    return l ? k : 4'(n - 4'd1 - k);
  endfunction

  assign nb        = nine ? 4'd9 : 4'd8;
  assign wmask     = nine ? 9'h1ff : 9'h0ff;
  assign tick      = (div == baud);
  assign lead      = ~hi[0];
  assign bit_k     = hi[4:1];
  assign last_half = (hi == 5'({nb, 1'b0} - 5'd1));
  assign samp      = (st == RUN) && tick && (lead ^ cpha);
  assign word_done = (st == RUN) && tick && last_half;
  assign busy      = (sync_cnt != '0);
  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign wr_data   = reg_wr && reg_addr == A_DATA && !hold_full;
  assign rd_data   = reg_rd && reg_addr == A_DATA;
  assign unused_ok = ^reg_wdata[15:9];

  assign sclk = ph ^ cpol;
  assign mosi = mosi_q;
  assign cs_n = cs_q;
  assign irq  = |(mask & {ovf, rxc, ~hold_full});

  always_comb begin
    rx_next = rxw;
    if (samp) rx_next[bpos(bit_k, lsb, nb)] = miso;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {10'd0, nine, lsb, cpha, cpol, rxen, en_req};
      A_BAUD:  reg_rdata = 16'(baud);
      A_MSET,
      A_MCLR:  reg_rdata = {13'd0, mask};
      A_STAT:  reg_rdata = {12'd0, busy, ovf, rxc, ~hold_full};
      A_DATA:  reg_rdata = {7'd0, rxd};
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req <= 1'b0; rxen <= 1'b1; cpol <= 1'b0; cpha <= 1'b0;
      lsb <= 1'b0; nine <= 1'b0; en_eff <= 1'b0; sync_cnt <= '0;
      baud <= '0; mask <= '0;
    end else begin
      if (wr_ctrl) begin
        rxen <= reg_wdata[1]; cpol <= reg_wdata[2]; cpha <= reg_wdata[3];
        lsb  <= reg_wdata[4]; nine <= reg_wdata[5];
      end
      if (wr_ctrl && reg_wdata[0] != en_req) begin
        en_req   <= reg_wdata[0];
        sync_cnt <= SW'(SYNC_CYCLES);
      end else if (busy) begin
        sync_cnt <= sync_cnt - 1'b1;
        if (sync_cnt == SW'(1)) en_eff <= en_req;
      end
      if (reg_wr && reg_addr == A_BAUD && !en_req && !en_eff)
        baud <= reg_wdata[BAUD_W-1:0];
      if (reg_wr && reg_addr == A_MSET) mask <= mask | reg_wdata[2:0];
      if (reg_wr && reg_addr == A_MCLR) mask <= mask & ~reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cs_q <= 1'b1; ph <= 1'b0; div <= '0; hi <= '0;
      txw <= '0; rxw <= '0; mosi_q <= 1'b0; hold <= '0; hold_full <= 1'b0;
    end else begin
      if (wr_data) begin
        hold      <= reg_wdata[MAXB-1:0];
        hold_full <= 1'b1;
      end
      if (!en_eff) begin
        st <= IDLE; cs_q <= 1'b1; ph <= 1'b0; div <= '0; hi <= '0;
      end else begin
        case (st)
          IDLE: if (hold_full) begin
            st <= RUN; cs_q <= 1'b0; div <= '0; hi <= '0; ph <= 1'b0;
            txw <= hold; hold_full <= 1'b0;
            if (!cpha) mosi_q <= hold[bpos(4'd0, lsb, nb)];
          end
          RUN: begin
            rxw <= rx_next;
            if (tick) begin
              div <= '0;
              ph  <= ~ph;
              if (last_half) begin
                if (hold_full) begin
                  txw <= hold; hold_full <= 1'b0; hi <= '0;
                  if (!cpha) mosi_q <= hold[bpos(4'd0, lsb, nb)];
                end else begin
                  st <= TAIL;
                end
              end else begin
                hi <= hi + 5'd1;
                if (cpha && lead)   mosi_q <= txw[bpos(bit_k, lsb, nb)];
                if (!cpha && !lead) mosi_q <= txw[bpos(bit_k + 4'd1, lsb, nb)];
              end
            end else begin
              div <= div + 1'b1;
            end
          end
          TAIL: if (tick) begin
            st <= IDLE; cs_q <= 1'b1; div <= '0;
          end else begin
            div <= div + 1'b1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc <= 1'b0; ovf <= 1'b0; rxd <= '0;
    end else begin
      if (reg_wr && reg_addr == A_STAT && reg_wdata[2]) ovf <= 1'b0;
      if (word_done && rxen) begin
        if (rxc && !rd_data) begin
          ovf <= 1'b1;
          rxd <= '0;
        end else begin
          rxd <= rx_next & wmask;
          rxc <= 1'b1;
        end
      end else if (rd_data) begin
        rxc <= 1'b0;
      end
      if (!rxen || (wr_ctrl && !reg_wdata[1])) rxc <= 1'b0;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cpol)) |-> $stable(sclk));
  // R9
  baud_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && $past(en_eff)) |-> $stable(baud));
  // R8
  en_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_eff) |-> $past(busy));
  // R6
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rxc));
  // R5
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxen |-> !rxc);
endmodule

// File: tb/spi_dbuf_master_test.sv
module spi_dbuf_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk, mosi, cs_n;
  logic miso = 1'b0;

  int checks = 0, errors = 0;
  int cpol_tb = 0, cpha_tb = 0, lsb_tb = 0, nb_tb = 8, baud_tb = 0;
  logic [8:0] slv [0:31];
  logic [8:0] mon [0:31];
  int wi = 0, mi = 0, sb = 0, ecnt = 0, cs_rises = 0;
  logic [8:0] srx = '0;
  time t_cs = 0, t_e1 = 0, t_e2 = 0, t_last = 0, t_rise = 0;

  spi_dbuf_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #2 clk = ~clk;

  function automatic int spos(int k);
    return lsb_tb != 0 ? k : nb_tb - 1 - k;
  endfunction

  task automatic adv();
    sb++;
    if (sb == nb_tb) begin
      mon[mi] = srx; mi++; wi++; sb = 0; srx = '0;
    end
  endtask

  always @(negedge cs_n) begin
    sb = 0; srx = '0; ecnt = 0; t_cs = $time;
    if (cpha_tb == 0) miso = slv[wi][spos(0)];
  end

  always @(posedge cs_n) begin
    cs_rises++; t_rise = $time;
  end

  always @(sclk) if (!cs_n && rst_n) begin
    automatic logic lead = (sclk != cpol[0]);
    ecnt++;
    if (ecnt == 1) t_e1 = $time;
    if (ecnt == 2) t_e2 = $time;
    t_last = $time;
    if (lead == (cpha_tb == 0)) begin
      srx[spos(sb)] = mosi;
      if (cpha_tb != 0) adv();
    end else begin
      if (cpha_tb == 0) adv();
      miso = slv[wi][spos(sb)];
    end
  end

  logic [31:0] cpol;
  assign cpol = cpol_tb;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    while (cs_n && n < 200) begin @(negedge clk); n++; end
    while (!cs_n && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_en(bit v, logic [15:0] fields);
    logic [15:0] d;
    wr_reg(3'd0, fields | 16'(v));
    peek(3'd4, d);
    chk("R8 busy after enable change", 32'(d[3]), 32'd1);
    repeat (4) @(negedge clk);
    peek(3'd4, d);
    chk("R8 busy cleared", 32'(d[3]), 32'd0);
  endtask

  task automatic cfg(int pol, int pha, int l, int nine, int bd, int rxen);
    logic [15:0] f;
    logic [15:0] d;
    f = 16'((nine << 5) | (l << 4) | (pha << 3) | (pol << 2) | (rxen << 1));
    wr_reg(3'd0, 16'(0));
    repeat (5) @(negedge clk);
    wr_reg(3'd1, 16'(bd));
    cpol_tb = pol; cpha_tb = pha; lsb_tb = l; nb_tb = nine ? 9 : 8; baud_tb = bd;
    wr_reg(3'd0, f);
    set_en(1'b1, f);
    rd_reg(3'd1, d);
    chk("R9 divider written while disabled", 32'(d), 32'(bd));
  endtask

  task automatic xfer(string req, logic [8:0] tx, logic [8:0] sv);
    logic [15:0] d;
    logic [8:0] m;
    m = (nb_tb == 9) ? 9'h1ff : 9'h0ff;
    slv[wi] = sv;
    wr_reg(3'd5, 16'(tx));
    wait_done();
    chk({req, " word seen by slave"}, 32'(mon[mi-1]), 32'(tx & m));
    chk("R1 first edge one half after select", 32'(t_e1 - t_cs), 32'((baud_tb + 1) * 4));
    chk("R1 half period", 32'(t_e2 - t_e1), 32'((baud_tb + 1) * 4));
    chk("R10 select release after last edge", 32'(t_rise - t_last), 32'((baud_tb + 1) * 4));
    chk("R2 idle clock level", 32'(sclk), 32'(cpol_tb));
    rd_reg(3'd4, d);
    chk("R5 receive complete set", 32'(d[1:0]), 32'h3);
    rd_reg(3'd5, d);
    chk({req, " received word"}, 32'(d), 32'(sv & m));
    peek(3'd4, d);
    chk("R5 read clears receive complete", 32'(d[1]), 32'd0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(3'd0, d); chk("R11 control reset", 32'(d), 32'h02);
    peek(3'd4, d); chk("R11 status reset", 32'(d), 32'h01);
    peek(3'd1, d); chk("R11 divider reset", 32'(d), 32'h0);
    chk("R11 select high", 32'(cs_n), 32'd1);
    chk("R11 clock low", 32'(sclk), 32'd0);
    chk("R11 irq low", 32'(irq), 32'd0);
  endtask

  task automatic t_modes();
    cfg(0, 0, 0, 0, 1, 1); xfer("R2 mode0", 9'h0a5, 9'h03c);
    cfg(0, 1, 1, 0, 0, 1); xfer("R3 mode1 lsb", 9'h096, 9'h05a);
    cfg(1, 0, 0, 1, 2, 1); xfer("R3 mode2 9bit", 9'h1a5, 9'h0c3);
    cfg(1, 1, 1, 1, 3, 1); xfer("R3 mode3 lsb 9bit", 9'h0f1, 9'h12e);
  endtask

  task automatic t_baud_lock();
    logic [15:0] d;
    wr_reg(3'd1, 16'h0007);
    rd_reg(3'd1, d);
    chk("R9 divider write ignored while enabled", 32'(d), 32'd3);
  endtask

  task automatic t_b2b_ovf();
    logic [15:0] d;
    int r0;
    cfg(0, 0, 0, 0, 1, 1);
    r0 = cs_rises;
    slv[wi] = 9'h011; slv[wi+1] = 9'h022;
    wr_reg(3'd5, 16'h0081);
    repeat (2) @(negedge clk);
    peek(3'd4, d);
    chk("R4 empty again after move to shifter", 32'(d[0]), 32'd1);
    wr_reg(3'd5, 16'h0042);
    peek(3'd4, d);
    chk("R4 data write clears empty", 32'(d[0]), 32'd0);
    wait_done();
    chk("R10 select held across two words", 32'(cs_rises - r0), 32'd1);
    chk("R10 first word", 32'(mon[mi-2]), 32'h81);
    chk("R10 second word", 32'(mon[mi-1]), 32'h42);
    rd_reg(3'd4, d);
    chk("R6 overflow status", 32'(d[2:0]), 32'h7);
    rd_reg(3'd5, d);
    chk("R6 overflowed word reads zero", 32'(d), 32'h0);
    wr_reg(3'd4, 16'h0004);
    peek(3'd4, d);
    chk("R6 write one clears overflow", 32'(d[3:0]), 32'h1);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr_reg(3'd2, 16'h0002);
    chk("R7 masked off while no word", 32'(irq), 32'd0);
    slv[wi] = 9'h055;
    wr_reg(3'd5, 16'h00c3);
    wait_done();
    chk("R7 irq on receive complete", 32'(irq), 32'd1);
    wr_reg(3'd3, 16'h0002);
    chk("R7 irq after mask clear", 32'(irq), 32'd0);
    peek(3'd2, d);
    chk("R7 mask readback", 32'(d), 32'd0);
    wr_reg(3'd2, 16'h0001);
    chk("R7 irq from empty flag", 32'(irq), 32'd1);
    wr_reg(3'd3, 16'h0001);
    rd_reg(3'd5, d);
    chk("R5 word after irq test", 32'(d), 32'h55);
  endtask

  task automatic t_rx_off();
    logic [15:0] d;
    cfg(0, 0, 0, 0, 0, 0);
    slv[wi] = 9'h099;
    wr_reg(3'd5, 16'h003e);
    wait_done();
    chk("R5 slave still got word with receiver off", 32'(mon[mi-1]), 32'h3e);
    peek(3'd4, d);
    chk("R5 receive complete stays clear", 32'(d[1]), 32'd0);
    peek(3'd5, d);
    chk("R5 discarded word leaves data unchanged", 32'(d), 32'h55);
  endtask

  task automatic t_dre_disabled();
    logic [15:0] d;
    wr_reg(3'd0, 16'h0002);
    repeat (5) @(negedge clk);
    cpol_tb = 0; cpha_tb = 0; lsb_tb = 0; nb_tb = 8;
    slv[wi] = 9'h0a6;
    wr_reg(3'd5, 16'h005b);
    repeat (3) @(negedge clk);
    peek(3'd4, d);
    chk("R4 word waits while disabled", 32'(d[0]), 32'd0);
    chk("R8 no transfer while disabled", 32'(cs_n), 32'd1);
    wr_reg(3'd0, 16'h0003);
    repeat (2) @(negedge clk);
    chk("R8 no transfer during sync", 32'(cs_n), 32'd1);
    wait_done();
    chk("R4 word sent after enable", 32'(mon[mi-1]), 32'h5b);
    rd_reg(3'd5, d);
    chk("R4 reply after enable", 32'(d), 32'ha6);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin slv[i] = '0; mon[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_baud_lock();
    t_b2b_ovf();
    t_irq();
    t_rx_off();
    t_dre_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule